// File: doc/BRIEF.md
# Stereo Volume Stage with Cosine Mute Ramp

This block scales each sample of a stereo playback stream on its way from the serial receiver to the later filtering. Two gains are multiplied together. A static gain comes from a 6-bit volume code and falls on a dB-linear curve that gets coarser near the bottom and ends in silence. A ramp gain moves along a raised-cosine curve, so that muting, unmuting, powering down and powering up never cause a step in the output.

The ramp moves one table step after a fixed number of valid samples. A user mute or unmute uses a long hold, and a change of the power enable uses a short hold. If the target changes while a ramp is running, the ramp turns around at its current step. Every result is rounded and saturated back to the input width and registered. A one-cycle flag marks the output sample on which a ramp reaches full gain or silence.

Top module: `stereo_vol_ramp`

## Requirements
- R1: While reset is held, and until the first valid sample after reset, `valid_o`, `left_o`, `right_o` and `ramp_done_o` are all zero. The ramp starts at step 0, which is silence.
- R2: `valid_o` is high exactly one cycle after each cycle in which `valid_i` is high. The sample outputs change only on those cycles and hold their values otherwise.
- R3: Volume codes 0 and 1 give unity gain. A code c from 2 to 51 attenuates by (c-1) dB. The volume multiplier is round(32768 * 10^(-dB/20)) in unsigned Q1.15.
- R4: Codes 52, 53, 54, 55 and 56 attenuate by 52, 54, 57, 60 and 66 dB, using the same multiplier formula.
- R5: Codes 57 to 63 give a multiplier of 0, so both outputs are 0.
- R6: With volume multiplier v and ramp multiplier r, the combined gain is g = floor((v*r + 16384) / 32768). Each output is floor((s*g + 16384) / 32768), saturated to the signed 24-bit range.
- R7: The ramp multiplier at step k (0 to 32) is round(32768 * (1 - cos(pi*k/32)) / 2). A sample is scaled with the step in effect before that sample advances the ramp.
- R8: When mute is set or cleared, the ramp advances one step every 32 valid samples. A full fade lasts 1024 samples.
- R9: When the power enable changes, the ramp advances one step every 4 valid samples. A full fade lasts 128 samples. Fading in requires power on and mute off; otherwise the ramp fades out.
- R10: If the target changes while a ramp is in progress, the ramp reverses from its current step without jumping. The hold count restarts, and its length is chosen by the input that changed.
- R11: `ramp_done_o` is high for exactly one cycle, together with `valid_o`, on the output of the sample that moved the ramp onto step 32 or step 0.
- R12: The ramp advances only on cycles in which `valid_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input sample strobe |
| left_i | input | 24 | Left sample, signed |
| right_i | input | 24 | Right sample, signed |
| vol_code_i | input | 6 | Volume code |
| mute_i | input | 1 | User mute request |
| pwr_en_i | input | 1 | Playback path power enable |
| valid_o | output | 1 | Output sample strobe |
| left_o | output | 24 | Scaled left sample |
| right_o | output | 24 | Scaled right sample |
| ramp_done_o | output | 1 | Ramp reached full gain or silence |

## Verification
The bench sweeps all 64 volume codes. A swapped entry in the coarse region, or an off-by-one where the 1 dB steps begin, would show up as a mismatched sample at that code. Full 1024-sample and 128-sample fades are compared sample by sample, so a design that used the wrong hold for the cause of the ramp would finish at the wrong sample and put its done flag in the wrong place. One test unmutes for part of a ramp and then mutes again, which catches a design that restarts from an end point instead of reversing. Gaps between valid samples during a fade catch a ramp that advances on idle cycles.

// File: rtl/svr_pkg.sv
package svr_pkg;

  function automatic real exp_pos(input real y);
    real term;
    real sum;
    sum  = 1.0;
    term = 1.0;
    for (int n = 1; n < 60; n++) begin
      term = term * y / real'(n);
      sum  = sum + term;
    end
    return sum;
  endfunction

  function automatic real cos_ser(input real x);
    real term;
    real sum;
    sum  = 1.0;
    term = 1.0;
    for (int n = 1; n < 24; n++) begin
      term = -term * x * x / real'((2 * n - 1) * (2 * n));
      sum  = sum + term;
    end
    return sum;
  endfunction

  // attenuation in dB for a volume code, -1 means silence
  function automatic int att_db(input int code);
    if (code <= 1) return 0;
    if (code <= 51) return code - 1;
    case (code)
      52:      return 52;
      53:      return 54;
      54:      return 57;
      55:      return 60;
      56:      return 66;
      default: return -1;
    endcase
  endfunction

  function automatic int vol_gain(input int code, input int unity);
    int  db;
    real lin;
    db = att_db(code);
    if (db < 0) return 0;
    lin = 1.0 / exp_pos(real'(db) * 2.302585092994046 / 20.0);
    return $rtoi(real'(unity) * lin + 0.5);
  endfunction

  function automatic int ramp_gain(input int k, input int steps, input int unity);
    real x;
    x = 3.141592653589793 * real'(k) / real'(steps);
    return $rtoi(real'(unity) * (1.0 - cos_ser(x)) / 2.0 + 0.5);
  endfunction

endpackage

// File: rtl/svr_vol_lut.sv
module svr_vol_lut #(
  parameter int CODE_W = 6,
  parameter int GAIN_W = 16
) (
  input  logic [CODE_W-1:0] code_i,
  output logic [GAIN_W-1:0] gain_o
);
  localparam int N     = 2 ** CODE_W;
  localparam int UNITY = 2 ** (GAIN_W - 1);

  logic [GAIN_W-1:0] tbl [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    localparam int G = svr_pkg::vol_gain(i, UNITY);
    assign tbl[i] = GAIN_W'(G);
  end

  assign gain_o = tbl[code_i];
endmodule

// File: rtl/svr_ramp_ctrl.sv
module svr_ramp_ctrl #(
  parameter int STEPS     = 32,
  parameter int HOLD_MUTE = 32,
  parameter int HOLD_PWR  = 4,
  parameter int GAIN_W    = 16,
  localparam int POS_W    = $clog2(STEPS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  logic              mute_i,
  input  logic              pwr_en_i,
  output logic [GAIN_W-1:0] gain_o,
  output logic [POS_W-1:0]  pos_o,
  output logic              done_o
);
  localparam int UNITY    = 2 ** (GAIN_W - 1);
  localparam int HOLD_MAX = (HOLD_MUTE > HOLD_PWR) ? HOLD_MUTE : HOLD_PWR;
  localparam int SUB_W    = (HOLD_MAX > 1) ? $clog2(HOLD_MAX) : 1;

  logic [GAIN_W-1:0] tbl [STEPS+1];
  for (genvar k = 0; k <= STEPS; k++) begin : g_cos
    localparam int G = svr_pkg::ramp_gain(k, STEPS, UNITY);
    assign tbl[k] = GAIN_W'(G);
  end

  logic [POS_W-1:0] pos_q, pos_d;
  logic [SUB_W-1:0] sub_q, sub_d, sub_base, hold_last;
  logic             mute_q, pwr_q, fast_q, fast_d, done_q, done_d;
  logic             pwr_chg, mute_chg, up, at_tgt;

  always_comb begin
    pwr_chg   = pwr_en_i ^ pwr_q;
    mute_chg  = mute_i ^ mute_q;
    // a power change picks the short hold, a mute change the long one
    fast_d    = pwr_chg ? 1'b1 : (mute_chg ? 1'b0 : fast_q);
    sub_base  = (pwr_chg | mute_chg) ? '0 : sub_q;
    hold_last = fast_d ? SUB_W'(HOLD_PWR - 1) : SUB_W'(HOLD_MUTE - 1);
    up        = pwr_en_i & ~mute_i;
    at_tgt    = up ? (pos_q == POS_W'(STEPS)) : (pos_q == '0);
    pos_d     = pos_q;
    sub_d     = sub_base;
    done_d    = 1'b0;
    if (step_i) begin
      if (at_tgt) begin
        sub_d = '0;
      end else if (sub_base == hold_last) begin
        sub_d  = '0;
        pos_d  = up ? pos_q + POS_W'(1) : pos_q - POS_W'(1);
        done_d = up ? (pos_q == POS_W'(STEPS - 1)) : (pos_q == POS_W'(1));
      end else begin
        sub_d = sub_base + SUB_W'(1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      sub_q  <= '0;
      mute_q <= 1'b0;
      pwr_q  <= 1'b0;
      fast_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      pos_q  <= pos_d;
      sub_q  <= sub_d;
      mute_q <= mute_i;
      pwr_q  <= pwr_en_i;
      fast_q <= fast_d;
      done_q <= done_d;
    end
  end

  assign gain_o = tbl[pos_q];
  assign pos_o  = pos_q;
  assign done_o = done_q;
endmodule

// File: rtl/svr_scale.sv
module svr_scale #(
  parameter int DATA_W = 24,
  parameter int GAIN_W = 16
) (
  input  logic signed [DATA_W-1:0] s_i,
  input  logic        [GAIN_W-1:0] g_i,
  output logic signed [DATA_W-1:0] s_o
);
  localparam int PW = DATA_W + GAIN_W + 1;
  localparam int SH = GAIN_W - 1;
  localparam int RW = PW - SH;
  localparam logic [PW-1:0] HALF = {{(PW-SH){1'b0}}, 1'b1, {(SH-1){1'b0}}};
  localparam logic signed [RW-1:0] MAXV = {{(RW-DATA_W+1){1'b0}}, {(DATA_W-1){1'b1}}};
  localparam logic signed [RW-1:0] MINV = {{(RW-DATA_W+1){1'b1}}, {(DATA_W-1){1'b0}}};

  logic signed [PW-1:0] prod, rnd;
  logic signed [RW-1:0] q;

  always_comb begin
    prod = $signed({{(GAIN_W+1){s_i[DATA_W-1]}}, s_i}) * $signed({{DATA_W{1'b0}}, 1'b0, g_i});
    rnd  = prod + $signed(HALF);
    q    = rnd[PW-1:SH];
    if (q > MAXV)      s_o = MAXV[DATA_W-1:0];
    else if (q < MINV) s_o = MINV[DATA_W-1:0];
    else               s_o = q[DATA_W-1:0];
  end
endmodule

// File: rtl/stereo_vol_ramp.sv
module stereo_vol_ramp #(
  parameter int DATA_W    = 24,
  parameter int CODE_W    = 6,
  parameter int GAIN_W    = 16,
  parameter int STEPS     = 32,
  parameter int HOLD_MUTE = 32,
  parameter int HOLD_PWR  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] left_i,
  input  logic [DATA_W-1:0] right_i,
  input  logic [CODE_W-1:0] vol_code_i,
  input  logic              mute_i,
  input  logic              pwr_en_i,
  output logic              valid_o,
  output logic [DATA_W-1:0] left_o,
  output logic [DATA_W-1:0] right_o,
  output logic              ramp_done_o
);
  localparam int POS_W = $clog2(STEPS + 1);
  localparam int SH    = GAIN_W - 1;

  logic [GAIN_W-1:0]   vol_gain, ramp_gain, mix_gain;
  logic [2*GAIN_W-1:0] mix_prod;
  logic [POS_W-1:0]    ramp_pos;

  svr_vol_lut #(.CODE_W(CODE_W), .GAIN_W(GAIN_W)) u_vol (
    .code_i (vol_code_i),
    .gain_o (vol_gain)
  );

  svr_ramp_ctrl #(
    .STEPS(STEPS), .HOLD_MUTE(HOLD_MUTE), .HOLD_PWR(HOLD_PWR), .GAIN_W(GAIN_W)
  ) u_ramp (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (valid_i),
    .mute_i   (mute_i),
    .pwr_en_i (pwr_en_i),
    .gain_o   (ramp_gain),
    .pos_o    (ramp_pos),
    .done_o   (ramp_done_o)
  );

  // combined gain stays within unity, so the low GAIN_W bits hold it
  always_comb begin
    mix_prod = vol_gain * ramp_gain + (2*GAIN_W)'(2 ** (SH - 1));
    mix_gain = mix_prod[SH +: GAIN_W];
  end

  logic signed [DATA_W-1:0] ch_in  [2];
  logic signed [DATA_W-1:0] ch_out [2];
  logic        [DATA_W-1:0] ch_q   [2];

  assign ch_in[0] = left_i;
  assign ch_in[1] = right_i;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    svr_scale #(.DATA_W(DATA_W), .GAIN_W(GAIN_W)) u_scale (
      .s_i (ch_in[c]),
      .g_i (mix_gain),
      .s_o (ch_out[c])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      ch_q[c] <= '0;
      else if (valid_i) ch_q[c] <= ch_out[c];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= valid_i;
  end

  assign left_o  = ch_q[0];
  assign right_o = ch_q[1];
endmodule

// File: rtl/svr_chk.sv
module svr_chk #(
  parameter int DATA_W = 24,
  parameter int CODE_W = 6,
  parameter int STEPS  = 32,
  localparam int POS_W = $clog2(STEPS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [CODE_W-1:0] vol_code_i,
  input logic              valid_o,
  input logic [DATA_W-1:0] left_o,
  input logic [DATA_W-1:0] right_o,
  input logic              ramp_done_o,
  input logic [POS_W-1:0]  ramp_pos_i
);
  localparam logic [CODE_W-1:0] SIL_CODE = CODE_W'(57);

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable(left_o) && $stable(right_o)); // R2
  AST_SILENT_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && vol_code_i >= SIL_CODE |=> left_o == '0 && right_o == '0); // R5
  AST_FLOOR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && ramp_pos_i == '0 |=> left_o == '0 && right_o == '0); // R7
  AST_POS_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_pos_i <= POS_W'(STEPS)); // R7
  AST_POS_ONE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_pos_i != $past(ramp_pos_i) |->
      $past(valid_i) && (ramp_pos_i == $past(ramp_pos_i) + POS_W'(1) ||
                         ramp_pos_i == $past(ramp_pos_i) - POS_W'(1))); // R12
  AST_DONE_WITH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_done_o |-> valid_o); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_done_o |=> !ramp_done_o); // R11
endmodule

bind stereo_vol_ramp svr_chk #(
  .DATA_W(DATA_W), .CODE_W(CODE_W), .STEPS(STEPS)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .vol_code_i  (vol_code_i),
  .valid_o     (valid_o),
  .left_o      (left_o),
  .right_o     (right_o),
  .ramp_done_o (ramp_done_o),
  .ramp_pos_i  (ramp_pos)
);

// File: tb/sim_stereo_vol_ramp.sv
module sim_stereo_vol_ramp;
  localparam int CLK_PERIOD = 10;
  localparam int NSTEP = 32;
  localparam int H_MUTE = 32;
  localparam int H_PWR = 4;

  logic clk = 1'b0, rst_n = 1'b0, valid = 1'b0, mute = 1'b0, pwr = 1'b0;
  logic [23:0] l_in = '0, r_in = '0;
  logic [5:0]  code = '0;
  logic        valid_o, ramp_done_o;
  logic [23:0] left_o, right_o;

  stereo_vol_ramp u0 (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .left_i(l_in), .right_i(r_in),
    .vol_code_i(code), .mute_i(mute), .pwr_en_i(pwr),
    .valid_o(valid_o), .left_o(left_o), .right_o(right_o), .ramp_done_o(ramp_done_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {int l; int r; bit d; string tag;} exp_t;
  exp_t sb[$];
  exp_t e;
  int n_cmp = 0, n_bad = 0;
  bit fin = 1'b0;
  int m_pos = 0, m_sub = 0;
  bit m_fast = 1'b1, m_mute = 1'b0, m_pwr = 1'b0;
  int last_l = 0, last_r = 0;

  function automatic int db_of(int c);
    if (c <= 1) return 0;
    if (c <= 51) return c - 1;
    case (c)
      52: return 52; 53: return 54; 54: return 57; 55: return 60; 56: return 66;
      default: return -1;
    endcase
  endfunction

  function automatic int vgain(int c);
    int db = db_of(c);
    if (db < 0) return 0;
    return $rtoi(32768.0 * (10.0 ** (-real'(db) / 20.0)) + 0.5);
  endfunction

  function automatic int rgain(int k);
    return $rtoi(32768.0 * (1.0 - $cos(3.141592653589793 * real'(k) / real'(NSTEP))) / 2.0 + 0.5);
  endfunction

  function automatic int scale(int s, int g);
    longint p = longint'(s) * longint'(g) + 64'sd16384;
    p = p >>> 15;
    if (p > 64'sd8388607) p = 64'sd8388607;
    if (p < -64'sd8388608) p = -64'sd8388608;
    return int'(p);
  endfunction

  function automatic int rnd24();
    logic signed [23:0] t;
    t = 24'($urandom);
    return int'(t);
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic send(int ls, int rs, int c, string tag);
    exp_t x;
    int g, hold;
    bit up, at;
    @(negedge clk);
    valid = 1'b1; l_in = ls[23:0]; r_in = rs[23:0]; code = c[5:0];
    g = (vgain(c) * rgain(m_pos) + 16384) >>> 15;
    x.l = scale(ls, g); x.r = scale(rs, g); x.d = 1'b0; x.tag = tag;
    up = m_pwr && !m_mute;
    at = up ? (m_pos == NSTEP) : (m_pos == 0);
    hold = m_fast ? H_PWR : H_MUTE;
    if (at) m_sub = 0;
    else if (m_sub == hold - 1) begin
      m_sub = 0;
      m_pos = up ? m_pos + 1 : m_pos - 1;
      x.d = (m_pos == (up ? NSTEP : 0));
    end else m_sub++;
    last_l = x.l; last_r = x.r;
    sb.push_back(x);
  endtask

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); valid = 1'b0; end
  endtask

  task automatic set_ctrl(bit mu, bit pw);
    @(negedge clk);
    valid = 1'b0;
    if (pw != m_pwr) begin m_fast = 1'b1; m_sub = 0; end
    else if (mu != m_mute) begin m_fast = 1'b0; m_sub = 0; end
    m_mute = mu; m_pwr = pw; mute = mu; pwr = pw;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // monitor: pop and compare as outputs appear
  always @(negedge clk) begin
    if (rst_n && !fin) begin
      if (valid_o) begin
        if (sb.size() == 0) check(1'b0, "R2", 1, 0);
        else begin
          e = sb.pop_front();
          check(int'($signed(left_o)) == e.l, e.tag, int'($signed(left_o)), e.l);
          check(int'($signed(right_o)) == e.r, e.tag, int'($signed(right_o)), e.r);
          check(ramp_done_o == e.d, "R11", int'(ramp_done_o), int'(e.d));
        end
      end else if (ramp_done_o) check(1'b0, "R11", 1, 0);
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!fin) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0 && left_o == '0 && right_o == '0 && !ramp_done_o, "R1", int'(left_o), 0);
    rst_n = 1'b1;
    idle(2);
    check(valid_o == 1'b0 && left_o == '0 && ramp_done_o == 1'b0, "R1", int'(valid_o), 0);

    // power-up fade-in, short hold
    set_ctrl(1'b0, 1'b1);
    for (int i = 0; i < 128; i++) send(rnd24(), rnd24(), 0, "R9");
    send(24'sh3ff000, -24'sh3ff000, 1, "R7");

    // volume sweep at full ramp
    for (int c = 0; c < 64; c++) begin
      string t;
      t = (c <= 51) ? "R3" : ((c <= 56) ? "R4" : "R5");
      send(8388607, -8388608, c, t);
      send(rnd24(), rnd24(), c, t);
    end
    for (int i = 0; i < 40; i++) send(rnd24(), rnd24(), int'($urandom_range(0, 63)), "R6");

    // output holds while idle
    idle(3);
    check(left_o == last_l[23:0] && right_o == last_r[23:0] && !valid_o, "R2", int'($signed(left_o)), last_l);

    // user mute, long hold
    set_ctrl(1'b1, 1'b1);
    for (int i = 0; i < 1030; i++) send(rnd24(), rnd24(), 0, "R8");

    // partial unmute then reverse
    set_ctrl(1'b0, 1'b1);
    for (int i = 0; i < 300; i++) send(rnd24(), rnd24(), 2, "R10");
    set_ctrl(1'b1, 1'b1);
    for (int i = 0; i < 300; i++) send(rnd24(), rnd24(), 2, "R10");

    // full unmute
    set_ctrl(1'b0, 1'b1);
    for (int i = 0; i < 1030; i++) send(rnd24(), rnd24(), 0, "R8");

    // power-down fade-out
    set_ctrl(1'b0, 1'b0);
    for (int i = 0; i < 132; i++) send(rnd24(), rnd24(), 0, "R9");

    // power-up with idle gaps: ramp only moves on valid samples
    set_ctrl(1'b0, 1'b1);
    for (int i = 0; i < 140; i++) begin
      send(rnd24(), rnd24(), 0, "R12");
      if (i % 3 == 2) idle(2);
    end

    idle(4);
    check(sb.size() == 0, "R2", sb.size(), 0);
    fin = 1'b1;
    summary();
    $finish;
  end
endmodule